// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits between the strobe decoder of a sector-programmed flash array and its sector write controller. Each decoded byte load arrives as one event carrying an address and a data byte. The block watches these loads for command sequences. For every load window it decides whether the controller may store the sector data. It also rules on whole-array erase requests, and it can override read data while identification mode is active.

Three flags are persistent: the software-protection enable and two boot-block locks. They are modelled as registers that only the power-on reset clears, so they survive the soft reset. Identification mode, the partial command match and the state of the current window are volatile and clear on either reset. For a set number of cycles after power-on, every load is ignored. The command addresses and key bytes are parameters, and they are compared on the low 15 address bits.

When a window is refused, the controller still runs its busy timer but stores nothing. The block reports the outcome through two separate pulses, permit and refuse, so the controller can tell the two cases apart.

Top module: `prot_cmd_seq`

## Requirements
- R1: After power-on, protection is off and both blocks are unlocked. A window of plain data loads closed by `win_end` gives exactly one `prog_go` pulse on the cycle after `win_end` is sampled, and no `prog_block`.
- R2: The prefix AA@5555h, 55@2AAAh, A0@5555h arms the current window, so the data loads that follow in it give `prog_go`. The same prefix also turns software protection on.
- R3: With protection on, a data window that did not begin with the prefix gives a single `prog_block` pulse on the cycle after `win_end`, and no `prog_go`.
- R4: The six-load sequence AA, 55, 80, AA, 55, 20 (at 5555h, 2AAAh, 5555h, 5555h, 2AAAh, 5555h) turns protection off. Later windows without a prefix then give `prog_go`.
- R5: A load that does not match the next expected step returns the matcher to idle and is itself dropped. A `win_end` also returns the matcher to idle. A prefix split in either way does not arm a window.
- R6: The extended sequence ending in 40h, followed by a seventh load whose address lies in the lowest 2^BOOT_AW bytes, locks the lower boot block. A data window that touches a locked block gives `prog_block`, while windows in other regions still give `prog_go`. The lock is permanent until power-on.
- R7: The same sequence with a seventh load in the highest 2^BOOT_AW bytes locks the upper block. The two locks are independent of each other.
- R8: The extended sequence ending in 10h pulses `erase_go` on the cycle after its last load if neither block is locked. If either block is locked, it pulses `erase_rej` instead.
- R9: AA, 55, 90 enters identification mode and AA, 55, F0 leaves it. In this mode `rd_data` returns 1Fh at address 0 and A4h at address 1. At address 2 it returns FFh if the lower block is locked and FEh if not. At the address with all upper bits set and low nibble 2h it returns the same for the upper block. Every other address returns 00h. Outside the mode, `rd_data` equals `arr_rdata`.
- R10: `rst_n` clears identification mode but keeps the protection flag and both locks. `por_n` clears all of them.
- R11: During the first PWRUP_CYC cycles after `por_n` is released, loads are ignored. A window closed in that period produces no pulse.
- R12: `prog_go` and `prog_block` are single-cycle pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also clears the persistent flags |
| rst_n | input | 1 | Soft reset, active low; the persistent flags survive it |
| ld_valid | input | 1 | Qualifies one decoded byte load |
| ld_addr | input | AW | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| win_end | input | 1 | The load window has timed out and the write cycle begins |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data, replaced by identification bytes in identification mode |
| prog_go | output | 1 | Pulse: store the loaded sector |
| prog_block | output | 1 | Pulse: run the busy timer but store nothing |
| erase_go | output | 1 | Pulse: whole-array erase allowed |
| erase_rej | output | 1 | Pulse: whole-array erase refused because of a lock |

## Verification
The bench targets prefixes that break in each possible way: a wrong address partway through, and a window timeout between keys. A matcher that kept its partial progress would wrongly arm the next window and emit `prog_go` where `prog_block` belongs. Lock tests compare windows inside and outside each boot block, and they read the lock codes back in identification mode. A lock applied to the wrong region or shared between both blocks would show up as a wrong pulse or a wrong FEh/FFh byte. The two resets are applied in turn to catch flags that are cleared by the soft reset, or kept across power-on. A window closed during the power-up delay must produce no pulse at all.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_X3, M_X4, M_X5, M_LOCK, M_DATA
  } mstate_t;

  typedef struct packed {
    logic arm;
    logic sdp_off;
    logic erase;
    logic id_in;
    logic id_out;
    logic lock_lo;
    logic lock_hi;
    logic data;
  } cmd_ev_t;

  function automatic logic key_hit(input logic [14:0] a, input logic [7:0] d,
                                   input logic [14:0] ka, input logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  function automatic logic [7:0] lock_code(input logic locked);
    return locked ? 8'hFF : 8'hFE;
  endfunction

endpackage

// File: rtl/prot_pwrup.sv
module prot_pwrup #(
  parameter int CYC = 625000
) (
  input  logic clk,
  input  logic por_n,
  output logic pwr_ok
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign pwr_ok = (cnt == LIM);
endmodule

// File: rtl/prot_matcher.sv
module prot_matcher
  import prot_pkg::*;
#(
  parameter int AW = 19,
  parameter int BOOT_AW = 14,
  parameter logic [14:0] CA1 = 15'h5555,
  parameter logic [14:0] CA2 = 15'h2AAA,
  parameter logic [7:0] KD_U1 = 8'hAA,
  parameter logic [7:0] KD_U2 = 8'h55,
  parameter logic [7:0] KD_PROG = 8'hA0,
  parameter logic [7:0] KD_EXT = 8'h80,
  parameter logic [7:0] KD_IDIN = 8'h90,
  parameter logic [7:0] KD_IDOUT = 8'hF0,
  parameter logic [7:0] KD_SDPOFF = 8'h20,
  parameter logic [7:0] KD_ERASE = 8'h10,
  parameter logic [7:0] KD_LOCK = 8'h40
) (
  input  logic          clk,
  input  logic          seq_rst_n,
  input  logic          ld_ok,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          win_end,
  output cmd_ev_t       ev
);
  mstate_t st, nxt;
  logic [14:0] a15;
  logic in_lo, in_hi, h1, h2;

  assign a15   = ld_addr[14:0];
  assign in_lo = (ld_addr[AW-1:BOOT_AW] == '0);
  assign in_hi = &ld_addr[AW-1:BOOT_AW];
  assign h1    = key_hit(a15, ld_data, CA1, KD_U1);
  assign h2    = key_hit(a15, ld_data, CA2, KD_U2);

  always_comb begin
    nxt = st;
    ev  = '0;
    if (win_end) begin
      nxt = M_IDLE;
    end else if (ld_ok) begin
      case (st)
        M_IDLE: begin
          if (h1) nxt = M_K1;
          else begin
            ev.data = 1'b1;
            nxt = M_DATA;
          end
        end
        M_K1: nxt = h2 ? M_K2 : M_IDLE;
        M_K2: begin
          nxt = M_IDLE;
          if (a15 == CA1) begin
            if (ld_data == KD_PROG) begin
              ev.arm = 1'b1;
              nxt = M_DATA;
            end else if (ld_data == KD_EXT) nxt = M_X3;
            else if (ld_data == KD_IDIN) ev.id_in = 1'b1;
            else if (ld_data == KD_IDOUT) ev.id_out = 1'b1;
          end
        end
        M_X3: nxt = h1 ? M_X4 : M_IDLE;
        M_X4: nxt = h2 ? M_X5 : M_IDLE;
        M_X5: begin
          nxt = M_IDLE;
          if (a15 == CA1) begin
            if (ld_data == KD_SDPOFF) ev.sdp_off = 1'b1;
            else if (ld_data == KD_ERASE) ev.erase = 1'b1;
            else if (ld_data == KD_LOCK) nxt = M_LOCK;
          end
        end
        M_LOCK: begin
          ev.lock_lo = in_lo;
          ev.lock_hi = in_hi;
          nxt = M_IDLE;
        end
        default: ev.data = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge seq_rst_n) begin
    if (!seq_rst_n) st <= M_IDLE;
    else st <= nxt;
  end
endmodule

// File: rtl/prot_state.sv
module prot_state
  import prot_pkg::*;
#(
  parameter int AW = 19,
  parameter int BOOT_AW = 14
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          seq_rst_n,
  input  cmd_ev_t       ev,
  input  logic          win_end,
  input  logic [AW-1:0] ld_addr,
  output logic          sdp_en,
  output logic          lock_lo,
  output logic          lock_hi,
  output logic          id_mode,
  output logic          win_hit_lock,
  output logic          prog_go,
  output logic          prog_block,
  output logic          erase_go,
  output logic          erase_rej
);
  logic armed, data_seen, permit, any_lock;

  function automatic logic addr_locked(input logic [AW-1:0] a, input logic llo, input logic lhi);
    return (llo && (a[AW-1:BOOT_AW] == '0)) || (lhi && (&a[AW-1:BOOT_AW]));
  endfunction

  assign any_lock = lock_lo | lock_hi;
  assign permit   = !(sdp_en && !armed) && !win_hit_lock;

  // persistent flags: cleared only by power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sdp_en  <= 1'b0;
      lock_lo <= 1'b0;
      lock_hi <= 1'b0;
    end else begin
      if (ev.arm) sdp_en <= 1'b1;
      else if (ev.sdp_off) sdp_en <= 1'b0;
      if (ev.lock_lo) lock_lo <= 1'b1;
      if (ev.lock_hi) lock_hi <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge seq_rst_n) begin
    if (!seq_rst_n) begin
      id_mode      <= 1'b0;
      armed        <= 1'b0;
      data_seen    <= 1'b0;
      win_hit_lock <= 1'b0;
      prog_go      <= 1'b0;
      prog_block   <= 1'b0;
      erase_go     <= 1'b0;
      erase_rej    <= 1'b0;
    end else begin
      prog_go    <= win_end && data_seen && permit;
      prog_block <= win_end && data_seen && !permit;
      erase_go   <= ev.erase && !any_lock;
      erase_rej  <= ev.erase && any_lock;
      if (ev.id_in) id_mode <= 1'b1;
      else if (ev.id_out) id_mode <= 1'b0;
      if (win_end) begin
        armed        <= 1'b0;
        data_seen    <= 1'b0;
        win_hit_lock <= 1'b0;
      end else begin
        if (ev.arm) armed <= 1'b1;
        if (ev.data) begin
          data_seen <= 1'b1;
          if (addr_locked(ld_addr, lock_lo, lock_hi)) win_hit_lock <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prot_id_rd.sv
module prot_id_rd #(
  parameter int AW = 19,
  parameter logic [7:0] MFR = 8'h1F,
  parameter logic [7:0] DEV = 8'hA4
) (
  input  logic          id_mode,
  input  logic          lock_lo,
  input  logic          lock_hi,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_rdata,
  output logic [7:0]    rd_data
);
  localparam logic [AW-1:0] A_MFR = AW'(0);
  localparam logic [AW-1:0] A_DEV = AW'(1);
  localparam logic [AW-1:0] A_LLO = AW'(2);

  function automatic logic [7:0] id_value(input logic [AW-1:0] a, input logic llo, input logic lhi);
    if (a == A_MFR) return MFR;
    if (a == A_DEV) return DEV;
    if (a == A_LLO) return prot_pkg::lock_code(llo);
    if ((&a[AW-1:4]) && (a[3:0] == 4'h2)) return prot_pkg::lock_code(lhi);
    return 8'h00;
  endfunction

  assign rd_data = id_mode ? id_value(rd_addr, lock_lo, lock_hi) : arr_rdata;
endmodule

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
  import prot_pkg::*;
#(
  parameter int AW = 19,
  parameter int BOOT_AW = 14,
  parameter int PWRUP_CYC = 625000,
  parameter logic [14:0] CA1 = 15'h5555,
  parameter logic [14:0] CA2 = 15'h2AAA,
  parameter logic [7:0] MFR = 8'h1F,
  parameter logic [7:0] DEV = 8'hA4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          win_end,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_rdata,
  output logic [7:0]    rd_data,
  output logic          prog_go,
  output logic          prog_block,
  output logic          erase_go,
  output logic          erase_rej
);
  logic pwr_ok, ld_ok, seq_rst_n;
  logic sdp_en, lock_lo, lock_hi, id_mode, win_hit_lock, ev_sdp_off;
  cmd_ev_t ev;

  assign seq_rst_n  = rst_n & por_n;
  assign ld_ok      = ld_valid & pwr_ok;
  assign ev_sdp_off = ev.sdp_off;

  prot_pwrup #(.CYC(PWRUP_CYC)) u_pwr (
    .clk(clk), .por_n(por_n), .pwr_ok(pwr_ok)
  );

  prot_matcher #(.AW(AW), .BOOT_AW(BOOT_AW), .CA1(CA1), .CA2(CA2)) u_match (
    .clk(clk), .seq_rst_n(seq_rst_n), .ld_ok(ld_ok), .ld_addr(ld_addr),
    .ld_data(ld_data), .win_end(win_end), .ev(ev)
  );

  prot_state #(.AW(AW), .BOOT_AW(BOOT_AW)) u_state (
    .clk(clk), .por_n(por_n), .seq_rst_n(seq_rst_n), .ev(ev), .win_end(win_end),
    .ld_addr(ld_addr), .sdp_en(sdp_en), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .id_mode(id_mode), .win_hit_lock(win_hit_lock), .prog_go(prog_go),
    .prog_block(prog_block), .erase_go(erase_go), .erase_rej(erase_rej)
  );

  prot_id_rd #(.AW(AW), .MFR(MFR), .DEV(DEV)) u_id (
    .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi), .rd_addr(rd_addr),
    .arr_rdata(arr_rdata), .rd_data(rd_data)
  );
endmodule

module prot_cmd_seq_chk (
  input logic clk,
  input logic por_n,
  input logic rst_n,
  input logic pwr_ok,
  input logic sdp_en,
  input logic lock_lo,
  input logic lock_hi,
  input logic ev_sdp_off,
  input logic win_hit_lock,
  input logic prog_go,
  input logic prog_block,
  input logic erase_go,
  input logic erase_rej
);
  AST_GO_BLOCK_EXCL: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !(prog_go && prog_block)); // R12
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    prog_go |=> !prog_go); // R12
  AST_BLOCK_PULSE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    prog_block |=> !prog_block); // R12
  AST_ERASE_LOCKED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (lock_lo || lock_hi) |-> !erase_go); // R8
  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !pwr_ok |-> !(prog_go || prog_block || erase_go || erase_rej)); // R11
  AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_lo |=> lock_lo); // R6
  AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_hi |=> lock_hi); // R7
  AST_SDP_OFF_CMD: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sdp_en) |-> $past(ev_sdp_off)); // R4
  AST_LOCKED_NO_GO: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    prog_go |-> !$past(win_hit_lock)); // R6
endmodule

bind prot_cmd_seq prot_cmd_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .pwr_ok(pwr_ok), .sdp_en(sdp_en),
  .lock_lo(lock_lo), .lock_hi(lock_hi), .ev_sdp_off(ev_sdp_off),
  .win_hit_lock(win_hit_lock), .prog_go(prog_go), .prog_block(prog_block),
  .erase_go(erase_go), .erase_rej(erase_rej)
);

// File: tb/tb_prot_cmd_seq.sv
module tb_prot_cmd_seq;
  localparam int AW = 19;
  localparam logic [3:0] E_GO = 4'b0001, E_BLK = 4'b0010, E_ERG = 4'b0100, E_ERR = 4'b1000;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, ld_valid = 1'b0, win_end = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0] ld_data = '0, arr_rdata = 8'h5A, rd_data;
  logic prog_go, prog_block, erase_go, erase_rej;

  int n_chk = 0, n_err = 0, nev = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  prot_cmd_seq #(.AW(AW), .PWRUP_CYC(16)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .win_end(win_end), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .prog_go(prog_go), .prog_block(prog_block),
    .erase_go(erase_go), .erase_rej(erase_rej)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected pulse for every pulse seen
  always @(negedge clk) begin
    logic [3:0] evv;
    evv = {erase_rej, erase_go, prog_block, prog_go};
    if (por_n && rst_n && evv != 4'b0) begin
      nev++;
      if (exp_q.size() == 0) check(1'b0, "spurious pulse", evv, 0);
      else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(evv == e, t, evv, e);
      end
    end
  end

  task automatic expect_ev(input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic wend();
    @(negedge clk); win_end = 1'b1;
    @(negedge clk); win_end = 1'b0;
  endtask

  task automatic unlock();
    ld(19'h05555, 8'hAA);
    ld(19'h02AAA, 8'h55);
  endtask

  task automatic short_cmd(input logic [7:0] k);
    unlock();
    ld(19'h05555, k);
  endtask

  task automatic ext_cmd(input logic [7:0] k);
    short_cmd(8'h80);
    short_cmd(k);
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_addr = a;
    #1 check(rd_data == e, t, rd_data, e);
  endtask

  task automatic quiet_window(input string t);
    int mark;
    mark = nev;
    wend();
    @(negedge clk);
    check(nev == mark, t, nev - mark, 0);
  endtask

  task automatic data_window(input logic [AW-1:0] a, input logic [3:0] e, input string t);
    ld(a, 8'h11);
    ld(a + 1'b1, 8'h22);
    expect_ev(e, t);
    wend();
    @(negedge clk);
  endtask

  task automatic power_on();
    por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_rd(19'h0, 8'h5A, "R9 reset read passes array data");
    power_on();
    // R11: window inside power-up delay is ignored
    ld(19'h00100, 8'h11);
    quiet_window("R11 load in power-up delay");
    repeat (20) @(negedge clk);

    data_window(19'h00100, E_GO, "R1 plain window permitted");
    short_cmd(8'hA0);
    data_window(19'h40000, E_GO, "R2 prefixed window permitted");
    data_window(19'h40000, E_BLK, "R3 unprefixed window refused");

    // R5: prefix split by timeout
    unlock();
    quiet_window("R5 partial prefix makes no pulse");
    ld(19'h05555, 8'hA0);
    data_window(19'h40010, E_BLK, "R5 timeout clears prefix");
    // R5: prefix split by wrong address
    ld(19'h05555, 8'hAA);
    ld(19'h01234, 8'h55);
    ld(19'h02AAA, 8'h55);
    ld(19'h05555, 8'hA0);
    data_window(19'h40020, E_BLK, "R5 mismatch clears prefix");
    short_cmd(8'hA0);
    data_window(19'h40030, E_GO, "R3 full prefix still permitted");

    ext_cmd(8'h20);
    quiet_window("R4 disable command no pulse");
    data_window(19'h40040, E_GO, "R4 window after disable");

    short_cmd(8'h90);
    wend();
    chk_rd(19'h00000, 8'h1F, "R9 id maker");
    chk_rd(19'h00001, 8'hA4, "R9 id device");
    chk_rd(19'h00002, 8'hFE, "R9 lower unlocked");
    chk_rd(19'h7FFF2, 8'hFE, "R9 upper unlocked");
    chk_rd(19'h00005, 8'h00, "R9 other id address");
    short_cmd(8'hF0);
    wend();
    chk_rd(19'h00000, 8'h5A, "R9 id exit");

    expect_ev(E_ERG, "R8 erase allowed");
    ext_cmd(8'h10);
    wend();

    ext_cmd(8'h40);
    ld(19'h00010, 8'h00);
    wend();
    data_window(19'h00200, E_BLK, "R6 lower block locked");
    data_window(19'h40000, E_GO, "R6 middle region writable");
    data_window(19'h7FF00, E_GO, "R7 upper still writable");
    expect_ev(E_ERR, "R8 erase refused when locked");
    ext_cmd(8'h10);
    wend();

    ext_cmd(8'h40);
    ld(19'h7C000, 8'h00);
    wend();
    data_window(19'h7FF00, E_BLK, "R7 upper block locked");
    short_cmd(8'h90);
    wend();
    chk_rd(19'h00002, 8'hFF, "R6 lower lock code");
    chk_rd(19'h7FFF2, 8'hFF, "R7 upper lock code");

    // R10: soft reset keeps flags, clears id mode
    short_cmd(8'hA0);
    data_window(19'h40000, E_GO, "R2 enable before soft reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_rd(19'h00000, 8'h5A, "R10 soft reset leaves id mode");
    data_window(19'h40000, E_BLK, "R10 protection survives soft reset");
    data_window(19'h00100, E_BLK, "R10 lock survives soft reset");

    power_on();
    repeat (20) @(negedge clk);
    data_window(19'h00100, E_GO, "R10 power-on clears flags");
    short_cmd(8'h90);
    wend();
    chk_rd(19'h00002, 8'hFE, "R10 lower lock cleared");
    chk_rd(19'h7FFF2, 8'hFE, "R10 upper lock cleared");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 all expected pulses seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule